// File: doc/BRIEF.md
# Skewed Floating-Point Operand Source

This block is a synthesizable stimulus engine for a fused multiply-add datapath under test. It emits a stream of operand triples. Each triple is three 64-bit IEEE double-precision words plus a 3-bit class tag per word. Uniform random bits seldom excite the interesting parts of such a datapath, so the source skews its draws. Operands within a triple share a nearby exponent, so additions cancel or overlap heavily. Mantissas can be built from long runs of equal bits to stress carry chains and rounding. Magnitudes can be mirrored exactly with either sign. Special encodings are injected on purpose: zeros, infinities, NaNs, denormals and the extreme finite values.

All randomness comes from one 64-bit maximal-length shift register. It is advanced 64 steps per clock, so every cycle yields a fresh word. Each triple is built by a small state machine:

- ANCHOR draws a shared base exponent and mantissa (ANCHOR to PICK, always).
- PICK draws a control word and chooses the class of the current slot (PICK to BUILD, always).
- BUILD shapes the current slot from the control word and a fresh mantissa word. BUILD goes back to PICK while a slot remains, and goes to OFFER after the third slot.
- OFFER presents the triple with valid high. OFFER goes to ANCHOR on a handshake and stays in OFFER otherwise.
- A seed load forces the machine to ANCHOR from any state. Reset also leaves it in ANCHOR.

Class mix and exponent window are set through a small write-only register file.

Top module: `skew_opgen`

## Requirements
- R1: Each accepted transfer carries three 64-bit operands (`op_a`, `op_b`, `op_c`) and three tags. The tag codes are 0 = uniform, 1 = correlated, 2 = run-pattern, 3 = mirrored, 4 = special. No other tag value is ever output.
- R2: The class of a slot comes from an 8-bit random draw `r` compared against four thresholds T0..T3, tested in that order. The slot is uniform if r<T0, otherwise correlated if r<T1, otherwise run-pattern if r<T2, otherwise mirrored if r<T3, otherwise special. A class whose window is empty (its threshold not above all earlier ones) is never emitted.
- R3: Correlated and run-pattern operands have an exponent field (bits 62:52) in the range 1..2046. That exponent lies within W of the triple's anchor exponent, where W is the 6-bit window register. So two such operands differ in exponent by at most 2W, and each differs from a mirrored operand of the same triple by at most W.
- R4: A run-pattern operand has a mantissa (bits 51:0) that is a constant background with one contiguous run of the opposite value. Scanning bits 0 to 51 therefore finds at most two value changes.
- R5: Mirrored operands of one triple all equal the anchor magnitude, so bits 62:0 match. The sign bit (63) is drawn independently, so both the x=y and x=-y cases occur.
- R6: A special operand is one of these eight encodings, with a random sign:
  - zero
  - infinity
  - quiet NaN (exponent all ones, bit 51 set)
  - signaling NaN (exponent all ones, bit 51 clear, bit 0 set)
  - denormal (exponent 0, nonzero mantissa)
  - smallest denormal (exponent 0, mantissa 1)
  - smallest normal (exponent 1, mantissa 0)
  - largest finite (exponent 2046, mantissa all ones)
- R7: While `out_valid` is high and `out_ready` is low, the operands and tags hold their values and `out_valid` stays high.
- R8: A new triple is produced only after a handshake. After a handshake edge or a seed-load edge, `out_valid` is low for six edges and returns high after the seventh. After reset release, `out_valid` first rises after the seventh edge.
- R9: Loading the same seed reproduces the same triple sequence exactly. A seed of zero is replaced by a fixed nonzero value, so the generator never locks up.
- R10: Configuration writes use `cfg_addr` as follows: 0..3 write T0..T3, and 4 writes W from `cfg_wdata[5:0]`. Writes to addresses 5..7 have no effect. Reset values are T0..T3 = 52, 104, 156, 208 and W = 4, so every class appears.
- R11: During and immediately after reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed_in` and restart triple construction |
| seed_in | input | 64 | Seed value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| out_valid | output | 1 | Triple available |
| out_ready | input | 1 | Consumer accepts the triple |
| op_a | output | 64 | First operand |
| op_b | output | 64 | Second operand |
| op_c | output | 64 | Third operand |
| cls_a | output | 3 | Class tag of `op_a` |
| cls_b | output | 3 | Class tag of `op_b` |
| cls_c | output | 3 | Class tag of `op_c` |

## Verification
After a seed load or a handshake, a fresh triple is due exactly eight falling-edge samples after the stimulus is applied. It is due seven samples after the release of reset, or after the seed pulse has been withdrawn. Every collection step counts samples until `out_valid` rises and compares the count to the figure for that stimulus. Operands and tags are then read once, at the falling edge where `out_valid` is first seen high, and judged against the encoding rule for each slot's tag. During a stall, the triple is compared at five further falling edges.

// File: rtl/ogen_pkg.sv
package ogen_pkg;

    localparam int FP_W  = 64;
    localparam int EXP_W = 11;
    localparam int MAN_W = 52;

    localparam logic [EXP_W-1:0] EXP_ONES   = '1;
    localparam logic [EXP_W-1:0] EXP_MAXFIN = EXP_ONES - 1'b1;

    // control word layout
    localparam int F_SIGN    = 8;
    localparam int F_OFF_LO  = 9;
    localparam int F_OFF_DIR = 15;
    localparam int F_RS_LO   = 16;
    localparam int F_RL_LO   = 22;
    localparam int F_BG      = 28;
    localparam int F_SK_LO   = 29;

    typedef enum logic [2:0] {
        CLS_UNI  = 3'd0,
        CLS_CORR = 3'd1,
        CLS_RUN  = 3'd2,
        CLS_MIR  = 3'd3,
        CLS_SPEC = 3'd4
    } opclass_t;

    typedef enum logic [1:0] {
        ST_ANCHOR = 2'd0,
        ST_PICK   = 2'd1,
        ST_BUILD  = 2'd2,
        ST_OFFER  = 2'd3
    } gen_state_t;

    function automatic logic [EXP_W-1:0] legal_exp(input logic [EXP_W-1:0] raw);
        if (raw == '0)
            return EXP_W'(1);
        else if (raw == EXP_ONES)
            return EXP_MAXFIN;
        else
            return raw;
    endfunction

endpackage

// File: rtl/ogen_lfsr.sv
module ogen_lfsr #(
    parameter int          W         = 64,
    parameter int          STEPS     = 64,
    parameter logic [63:0] BOOT_SEED = 64'h9E37_79B9_7F4A_7C15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         advance,
    output logic [W-1:0] word
);
    logic [W-1:0] state_q;
    logic [W-1:0] leap;

    // x^64 + x^63 + x^61 + x^60 + 1, stepped STEPS times per clock
    always_comb begin
        leap = state_q;
        for (int i = 0; i < STEPS; i++) begin
            leap = {leap[W-2:0], leap[W-1] ^ leap[W-2] ^ leap[W-4] ^ leap[W-5]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BOOT_SEED[W-1:0];
        else if (load)
            state_q <= (seed == '0) ? BOOT_SEED[W-1:0] : seed;
        else if (advance)
            state_q <= leap;
    end

    assign word = state_q;

    assert_state_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/ogen_class_pick.sv
module ogen_class_pick
    import ogen_pkg::*;
#(
    parameter int SEL_W = 8,
    parameter int NTHR  = 4
) (
    input  logic [SEL_W-1:0]           draw,
    input  logic [NTHR-1:0][SEL_W-1:0] thr,
    output opclass_t                   cls
);
    // first threshold (lowest index) exceeding the draw wins
    always_comb begin
        cls = CLS_SPEC;
        for (int k = NTHR - 1; k >= 0; k--) begin
            if (draw < thr[k])
                cls = opclass_t'(3'(k));
        end
    end

endmodule

// File: rtl/ogen_shaper.sv
module ogen_shaper
    import ogen_pkg::*;
#(
    parameter int WIN_W = 6
) (
    input  opclass_t         cls,
    input  logic [FP_W-1:0]  ctrl,
    input  logic [FP_W-1:0]  mw,
    input  logic [EXP_W-1:0] anc_exp,
    input  logic [MAN_W-1:0] anc_man,
    input  logic [WIN_W-1:0] win,
    output logic [FP_W-1:0]  value
);
    localparam int EW2 = EXP_W + 2;

    logic             sgn;
    logic [WIN_W-1:0] off;
    logic [EW2-1:0]   base;
    logic [EW2-1:0]   delta;
    logic [EW2-1:0]   e_wide;
    logic [EXP_W-1:0] e_near;
    logic [5:0]       st6;
    logic [6:0]       rs;
    logic [6:0]       rlen;
    logic [7:0]       rend;
    logic [MAN_W-1:0] run_man;
    logic [FP_W-1:0]  special;

    assign sgn = ctrl[F_SIGN];

    // exponent near the anchor, clamped into the normal range
    always_comb begin
        off    = ctrl[F_OFF_LO +: WIN_W] & win;
        base   = {2'b00, anc_exp};
        delta  = EW2'(off);
        e_wide = ctrl[F_OFF_DIR] ? (base - delta) : (base + delta);
        if (e_wide[EW2-1] || e_wide == '0)
            e_near = EXP_W'(1);
        else if (e_wide > EW2'(EXP_MAXFIN))
            e_near = EXP_MAXFIN;
        else
            e_near = e_wide[EXP_W-1:0];
    end

    // one run of inverted bits over a constant background
    always_comb begin
        st6  = ctrl[F_RS_LO +: 6];
        rs   = (st6 > 6'd51) ? (7'(st6) - 7'd12) : 7'(st6);
        rlen = 7'(ctrl[F_RL_LO +: 6]) + 7'd1;
        rend = 8'(rs) + 8'(rlen);
        for (int i = 0; i < MAN_W; i++) begin
            run_man[i] = ctrl[F_BG] ^ ((8'(i) >= 8'(rs)) && (8'(i) < rend));
        end
    end

    always_comb begin
        unique case (ctrl[F_SK_LO +: 3])
            3'd0: special = {sgn, {EXP_W{1'b0}}, {MAN_W{1'b0}}};
            3'd1: special = {sgn, EXP_ONES, {MAN_W{1'b0}}};
            3'd2: special = {sgn, EXP_ONES, 1'b1, mw[MAN_W-2:0]};
            3'd3: special = {sgn, EXP_ONES, 1'b0, mw[MAN_W-2:1], 1'b1};
            3'd4: special = {sgn, {EXP_W{1'b0}}, mw[MAN_W-1:1], 1'b1};
            3'd5: special = {sgn, EXP_W'(1), {MAN_W{1'b0}}};
            3'd6: special = {sgn, EXP_MAXFIN, {MAN_W{1'b1}}};
            default: special = {sgn, {EXP_W{1'b0}}, MAN_W'(1)};
        endcase
    end

    always_comb begin
        unique case (cls)
            CLS_UNI:  value = mw;
            CLS_CORR: value = {sgn, e_near, mw[MAN_W-1:0]};
            CLS_RUN:  value = {sgn, e_near, run_man};
            CLS_MIR:  value = {sgn, anc_exp, anc_man};
            CLS_SPEC: value = special;
            default:  value = mw;
        endcase
    end

endmodule

// File: rtl/skew_opgen.sv
module skew_opgen
    import ogen_pkg::*;
#(
    parameter int          SEL_W     = 8,
    parameter int          WIN_W     = 6,
    parameter int          STEPS     = 64,
    parameter logic [63:0] BOOT_SEED = 64'h9E37_79B9_7F4A_7C15,
    parameter logic [7:0]  THR0_INIT = 8'd52,
    parameter logic [7:0]  THR1_INIT = 8'd104,
    parameter logic [7:0]  THR2_INIT = 8'd156,
    parameter logic [7:0]  THR3_INIT = 8'd208,
    parameter logic [5:0]  WIN_INIT  = 6'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic [63:0]      seed_in,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [SEL_W-1:0] cfg_wdata,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [63:0]      op_a,
    output logic [63:0]      op_b,
    output logic [63:0]      op_c,
    output logic [2:0]       cls_a,
    output logic [2:0]       cls_b,
    output logic [2:0]       cls_c
);
    localparam int NSLOT = 3;
    localparam int NTHR  = 4;
    localparam int IDX_W = $clog2(NSLOT);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NSLOT - 1);
    localparam logic [2:0] ADDR_WIN = 3'(NTHR);

    gen_state_t st_q, st_d;

    logic [FP_W-1:0]              word;
    logic                         lfsr_adv;
    logic                         take;
    logic [NTHR-1:0][SEL_W-1:0]   thr_q;
    logic [WIN_W-1:0]             win_q;
    logic [EXP_W-1:0]             anc_exp_q;
    logic [MAN_W-1:0]             anc_man_q;
    logic [FP_W-1:0]              ctrl_q;
    opclass_t                     cls_q;
    opclass_t                     cls_pick;
    logic [IDX_W-1:0]             slot_q;
    logic [FP_W-1:0]              shaped;
    logic [NSLOT-1:0][FP_W-1:0]   val_q;
    logic [NSLOT-1:0][2:0]        tag_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_ANCHOR;
        else
            st_q <= st_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (seed_load) begin
            st_d = ST_ANCHOR;
        end else begin
            unique case (st_q)
                ST_ANCHOR: st_d = ST_PICK;
                ST_PICK:   st_d = ST_BUILD;
                ST_BUILD:  st_d = (slot_q == LAST_SLOT) ? ST_OFFER : ST_PICK;
                ST_OFFER:  st_d = out_ready ? ST_ANCHOR : ST_OFFER;
                default:   st_d = ST_ANCHOR;
            endcase
        end
    end

    // ---------------- state outputs ----------------
    always_comb begin
        out_valid = (st_q == ST_OFFER);
        lfsr_adv  = (st_q != ST_OFFER);
        take      = out_valid && out_ready;
    end

    ogen_lfsr #(
        .W(FP_W), .STEPS(STEPS), .BOOT_SEED(BOOT_SEED)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_in),
        .advance(lfsr_adv), .word(word)
    );

    ogen_class_pick #(.SEL_W(SEL_W), .NTHR(NTHR)) u_pick (
        .draw(word[SEL_W-1:0]), .thr(thr_q), .cls(cls_pick)
    );

    ogen_shaper #(.WIN_W(WIN_W)) u_shape (
        .cls(cls_q), .ctrl(ctrl_q), .mw(word),
        .anc_exp(anc_exp_q), .anc_man(anc_man_q), .win(win_q),
        .value(shaped)
    );

    // ---------------- configuration ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= {THR3_INIT, THR2_INIT, THR1_INIT, THR0_INIT};
            win_q <= WIN_INIT;
        end else if (cfg_we) begin
            if (cfg_addr < ADDR_WIN)
                thr_q[cfg_addr[IDX_W-1:0]] <= cfg_wdata;
            else if (cfg_addr == ADDR_WIN)
                win_q <= cfg_wdata[WIN_W-1:0];
        end
    end

    // ---------------- anchor, control and slot index ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            anc_exp_q <= EXP_W'(1);
            anc_man_q <= '0;
            ctrl_q    <= '0;
            cls_q     <= CLS_UNI;
            slot_q    <= '0;
        end else if (seed_load) begin
            slot_q <= '0;
        end else begin
            unique case (st_q)
                ST_ANCHOR: begin
                    anc_exp_q <= legal_exp(word[FP_W-2 -: EXP_W]);
                    anc_man_q <= word[MAN_W-1:0];
                    slot_q    <= '0;
                end
                ST_PICK: begin
                    ctrl_q <= word;
                    cls_q  <= cls_pick;
                end
                ST_BUILD: slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- per-slot operand registers ----------------
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q[g] <= '0;
                tag_q[g] <= CLS_UNI;
            end else if (!seed_load && st_q == ST_BUILD && slot_q == IDX_W'(g)) begin
                val_q[g] <= shaped;
                tag_q[g] <= cls_q;
            end
        end
    end

    assign op_a  = val_q[0];
    assign op_b  = val_q[1];
    assign op_c  = val_q[2];
    assign cls_a = tag_q[0];
    assign cls_b = tag_q[1];
    assign cls_c = tag_q[2];

    // ---------------- assertions ----------------
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !seed_load) |=>
            (out_valid && $stable(op_a) && $stable(op_b) && $stable(op_c)
             && $stable(cls_a) && $stable(cls_b) && $stable(cls_c)));

    assert_new_only_on_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !out_valid);

    assert_tag_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cls_a <= 3'd4 && cls_b <= 3'd4 && cls_c <= 3'd4));

    assert_mirror_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cls_a == CLS_MIR && cls_b == CLS_MIR) |-> (op_a[62:0] == op_b[62:0]));

    assert_corr_exp_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cls_c == CLS_CORR) |-> (op_c[62:52] != '0 && op_c[62:52] != '1));

endmodule

// File: tb/sim_skew_opgen.sv
module sim_skew_opgen;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [63:0] seed_in = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [63:0] op_a, op_b, op_c;
    logic [2:0]  cls_a, cls_b, cls_c;

    skew_opgen u0 (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_ready(out_ready),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int          cur_win = 4;
    logic [63:0] v [3];
    logic [2:0]  t [3];
    logic [7:0]  seen;
    logic [7:0]  kinds;
    bit          sign_split;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int sp_kind(input logic [63:0] x);
        logic [10:0] e = x[62:52];
        logic [51:0] m = x[51:0];
        if (e == 0 && m == 0) return 0;
        if (e == 11'h7FF && m == 0) return 1;
        if (e == 11'h7FF && m[51]) return 2;
        if (e == 11'h7FF && m[0]) return 3;
        if (e == 0 && m == 1) return 7;
        if (e == 0) return 4;
        if (e == 1 && m == 0) return 5;
        if (e == 11'd2046 && m == '1) return 6;
        return -1;
    endfunction

    function automatic int flips(input logic [51:0] m);
        int n = 0;
        for (int i = 0; i < 51; i++) if (m[i] != m[i+1]) n++;
        return n;
    endfunction

    function automatic int edist(input logic [63:0] x, input logic [63:0] y);
        int d = int'(x[62:52]) - int'(y[62:52]);
        return (d < 0) ? -d : d;
    endfunction

    task automatic cfg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 3'd4) cur_win = int'(d[5:0]);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_thr(input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c, input logic [7:0] d);
        cfg(3'd0, a); cfg(3'd1, b); cfg(3'd2, c); cfg(3'd3, d);
    endtask

    task automatic load_seed(input logic [63:0] s);
        @(negedge clk);
        seed_in = s; seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    // count falling edges until valid is seen; returns the count
    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!out_valid && n < 300);
        if (!out_valid) chk(1'b0, "R8", "watchdog: no valid", 64'(n), 64'd0);
    endtask

    task automatic check_triple(input logic [7:0] allowed);
        for (int s = 0; s < 3; s++) begin
            chk(t[s] <= 3'd4, "R1", "tag code", 64'(t[s]), 64'd4);
            chk(allowed[t[s]], "R2", "tag from empty window", 64'(t[s]), 64'(allowed));
            seen[t[s]] = 1'b1;
            if (t[s] == 3'd1 || t[s] == 3'd2)
                chk(v[s][62:52] != 0 && v[s][62:52] != 11'h7FF, "R3", "exponent range",
                    v[s], 64'd0);
            if (t[s] == 3'd2)
                chk(flips(v[s][51:0]) <= 2, "R4", "run mantissa flips",
                    64'(flips(v[s][51:0])), 64'd2);
            if (t[s] == 3'd4) begin
                chk(sp_kind(v[s]) >= 0, "R6", "special encoding", v[s], 64'd0);
                if (sp_kind(v[s]) >= 0) kinds[sp_kind(v[s])] = 1'b1;
            end
        end
        for (int s = 0; s < 3; s++) begin
            for (int u = s + 1; u < 3; u++) begin
                if ((t[s] == 3'd1 || t[s] == 3'd2) && (t[u] == 3'd1 || t[u] == 3'd2))
                    chk(edist(v[s], v[u]) <= 2 * cur_win, "R3", "pair exponent gap",
                        64'(edist(v[s], v[u])), 64'(2 * cur_win));
                if ((t[s] == 3'd3 && (t[u] == 3'd1 || t[u] == 3'd2)) ||
                    (t[u] == 3'd3 && (t[s] == 3'd1 || t[s] == 3'd2)))
                    chk(edist(v[s], v[u]) <= cur_win, "R3", "gap to anchor",
                        64'(edist(v[s], v[u])), 64'(cur_win));
                if (t[s] == 3'd3 && t[u] == 3'd3) begin
                    chk(v[s][62:0] == v[u][62:0], "R5", "mirror magnitude",
                        v[s], v[u]);
                    if (v[s][63] != v[u][63]) sign_split = 1'b1;
                end
            end
        end
    endtask

    task automatic take(input int exp_n, input logic [7:0] allowed);
        int n;
        out_ready = 1'b1;
        wait_valid(n);
        if (exp_n > 0)
            chk(n == exp_n, "R8", "cycles to valid", 64'(n), 64'(exp_n));
        v[0] = op_a; v[1] = op_b; v[2] = op_c;
        t[0] = cls_a; t[1] = cls_b; t[2] = cls_c;
        check_triple(allowed);
    endtask

    task automatic run_mix(input int cnt, input logic [7:0] allowed);
        seen = '0; kinds = '0; sign_split = 1'b0;
        take(7, allowed);
        for (int i = 1; i < cnt; i++) take(8, allowed);
    endtask

    task automatic t_reset_and_defaults;
        int n;
        out_ready = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        chk(out_valid == 1'b0, "R11", "valid after reset", 64'(out_valid), 64'd0);
        wait_valid(n);
        chk(n == 7, "R8", "first valid after reset", 64'(n), 64'd7);
        seen = '0; kinds = '0; sign_split = 1'b0;
        for (int i = 0; i < 60; i++) take(8, 8'h1F);
        chk(seen[4:0] == 5'h1F, "R10", "default mix covers all classes",
            64'(seen), 64'h1F);
    endtask

    task automatic t_corr_mirror;
        set_thr(8'd0, 8'd128, 8'd128, 8'd255);
        cfg(3'd4, 8'd5);
        load_seed(64'h0123_4567_89AB_CDEF);
        run_mix(40, 8'b0001_1010);
        chk(seen[1] && seen[3], "R2", "correlated and mirrored both seen",
            64'(seen), 64'h0A);
    endtask

    task automatic t_zero_window;
        set_thr(8'd0, 8'd255, 8'd255, 8'd255);
        cfg(3'd4, 8'd0);
        load_seed(64'hDEAD_BEEF_0BAD_F00D);
        run_mix(25, 8'b0001_0010);
        chk(seen[1], "R3", "correlated seen with W=0", 64'(seen), 64'h02);
    endtask

    task automatic t_runs;
        set_thr(8'd0, 8'd0, 8'd255, 8'd255);
        cfg(3'd4, 8'd63);
        load_seed(64'h5555_AAAA_3333_CCCC);
        run_mix(30, 8'b0001_0100);
        chk(seen[2], "R4", "run class seen", 64'(seen), 64'h04);
    endtask

    task automatic t_mirror;
        set_thr(8'd0, 8'd0, 8'd0, 8'd255);
        load_seed(64'h0F0F_1234_8765_F0F0);
        run_mix(25, 8'b0001_1000);
        chk(sign_split, "R5", "opposite-sign mirror seen", 64'(sign_split), 64'd1);
    endtask

    task automatic t_special;
        set_thr(8'd0, 8'd0, 8'd0, 8'd0);
        cfg(3'd5, 8'hFF); cfg(3'd6, 8'hFF); cfg(3'd7, 8'hFF);
        load_seed(64'h1357_9BDF_2468_ACE0);
        run_mix(50, 8'b0001_0000);
        chk(kinds == 8'hFF, "R6", "all special kinds seen", 64'(kinds), 64'hFF);
        chk(seen == 8'h10, "R10", "writes to 5..7 ignored", 64'(seen), 64'h10);
    endtask

    task automatic t_hold;
        int n;
        logic [63:0] ha, hb, hc;
        logic [2:0]  ta, tb, tc;
        set_thr(8'd52, 8'd104, 8'd156, 8'd208);
        cfg(3'd4, 8'd4);
        out_ready = 1'b0;
        load_seed(64'hCAFE_F00D_1234_5678);
        wait_valid(n);
        chk(n == 7, "R8", "valid after seed load", 64'(n), 64'd7);
        ha = op_a; hb = op_b; hc = op_c; ta = cls_a; tb = cls_b; tc = cls_c;
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b1, "R7", "valid held", 64'(out_valid), 64'd1);
        chk(op_a == ha && op_b == hb && op_c == hc, "R7", "operands held", op_a, ha);
        chk(cls_a == ta && cls_b == tb && cls_c == tc, "R7", "tags held",
            64'({cls_a, cls_b, cls_c}), 64'({ta, tb, tc}));
        take(8, 8'h1F);
    endtask

    task automatic t_repro;
        logic [63:0] rec [12];
        logic [63:0] first_x;
        logic [63:0] z0;
        load_seed(64'hA5A5_0000_FFFF_1111);
        for (int i = 0; i < 4; i++) begin
            take(i == 0 ? 7 : 8, 8'h1F);
            rec[3*i] = v[0]; rec[3*i+1] = v[1]; rec[3*i+2] = v[2];
        end
        first_x = rec[0] ^ rec[1] ^ rec[2];
        load_seed(64'hA5A5_0000_FFFF_1111);
        for (int i = 0; i < 4; i++) begin
            take(i == 0 ? 7 : 8, 8'h1F);
            chk(v[0] == rec[3*i] && v[1] == rec[3*i+1] && v[2] == rec[3*i+2],
                "R9", "same seed same triple", v[0], rec[3*i]);
        end
        load_seed(64'h0000_0000_0000_0001);
        take(7, 8'h1F);
        chk((v[0] ^ v[1] ^ v[2]) != first_x, "R9", "other seed differs",
            v[0] ^ v[1] ^ v[2], first_x);
        load_seed(64'd0);
        take(7, 8'h1F);
        z0 = v[0] ^ v[1] ^ v[2];
        take(8, 8'h1F);
        chk((v[0] ^ v[1] ^ v[2]) != z0, "R9", "zero seed not stuck",
            v[0] ^ v[1] ^ v[2], z0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "global watchdog expired", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset_and_defaults();
        t_corr_mirror();
        t_zero_window();
        t_runs();
        t_mirror();
        t_special();
        t_hold();
        t_repro();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule